// File: doc/BRIEF.md
# Byte-Swapping Configuration Access Bridge

This block sits between a big-endian processor port and a little-endian PCI configuration requester. Every processor access that lands in the 16 MB configuration window is turned into a single configuration request. The outgoing address keeps the low 24 address bits of the processor address and forces bit 31 high, so the upper byte of the window base never reaches the PCI side.

Data lanes are reordered according to the access size. Word accesses reverse all four bytes and halfword accesses exchange two bytes. Byte accesses pass through unchanged. The same rule applies to write data going out and to read data coming back, and any lane that the access size does not cover is driven to zero.

A request is captured from a one-cycle write or read strobe. It is then held on the configuration side until the requester acknowledges it. During that time the block reports busy to the processor. A read result is returned with a one-cycle valid pulse.

Top module: `cfg_swap_bridge`

## Requirements
- R1: After reset, `cfg_req`, `cpu_busy` and `cpu_rvalid` are all low.
- R2: The configuration address of a request equals `cpu_addr` with bits 31..24 cleared and bit 31 set (`(cpu_addr & 0x00FFFFFF) | 0x80000000`).
- R3: With size code 2 (word), write data goes out with its four bytes reversed: byte 0 goes to lane 3, byte 1 to lane 2, and so on.
- R4: With size code 1 (halfword), bytes 0 and 1 of the write data are exchanged in lanes 0 and 1, and lanes 3..2 of `cfg_wdata` are zero.
- R5: With size code 0 (byte), byte 0 of the write data appears unchanged in lane 0, and lanes 3..1 are zero.
- R6: Read data returned on `cfg_rdata` is reordered by the size of the pending request, using the rules of R3 to R5. It appears on `cpu_rdata` together with a `cpu_rvalid` pulse of exactly one cycle, in the cycle after the cycle in which `cfg_ack` is sampled high. A write produces no `cpu_rvalid`.
- R7: A request is accepted at the clock edge that samples a strobe while the block is idle. `cfg_req` and `cpu_busy` rise in the next cycle. `cfg_req`, `cfg_addr`, `cfg_size`, `cfg_we` and `cfg_wdata` stay constant until the edge that samples `cfg_ack`, and both `cfg_req` and `cpu_busy` are low in the cycle after that edge.
- R8: Strobes that arrive while a request is pending are ignored. They neither change the pending request nor start a new one.
- R9: Size code 3 is reserved. A strobe carrying it starts no request.
- R10: If `cpu_wr` and `cpu_rd` are high together, the access is taken as a write (`cfg_we` high).
- R11: `cfg_size` carries the accepted size code unchanged: 0 for byte, 1 for halfword, 2 for word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 32 | Processor address within the configuration window |
| cpu_size | input | 2 | Access size code (0 byte, 1 halfword, 2 word, 3 reserved) |
| cpu_wdata | input | 32 | Processor write data, big-endian lane order |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_busy | output | 1 | A request is pending on the configuration side |
| cpu_rvalid | output | 1 | One-cycle pulse marking valid read data |
| cpu_rdata | output | 32 | Reordered read data |
| cfg_req | output | 1 | Configuration request, held until acknowledged |
| cfg_we | output | 1 | Request is a write |
| cfg_addr | output | 32 | Configuration address |
| cfg_size | output | 2 | Size code of the request |
| cfg_wdata | output | 32 | Reordered write data |
| cfg_ack | input | 1 | Requester accepts the request (and, for reads, supplies data) |
| cfg_rdata | input | 32 | Little-endian read data, valid with `cfg_ack` |

## Verification
The request outputs are due one cycle after the edge that samples a strobe. The bench checks them in the middle of that cycle, and again one cycle later to confirm that they hold. A read result and its valid pulse are due one cycle after the edge that samples `cfg_ack`. In that same cycle `cfg_req` and `cpu_busy` must already be low, and the bench checks all three there. The bench checks `cpu_rvalid` once more a cycle later to confirm that the pulse has ended. Strobes that the block must ignore are sampled by the bench at their own edge, and their effect is judged from the ports in the following cycles.

// File: rtl/cfgb_pkg.sv
// Shared types and constants for the configuration access bridge.
// Assumes a 32-bit data path split into four byte lanes.
package cfgb_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } req_state_e;

endpackage

// File: rtl/cfgb_addr_map.sv
// Forms the configuration address from the processor address.
// Keeps the low WIN_BITS bits and forces the top address bit high.
// Assumes WIN_BITS < ADDR_W - 1.
module cfgb_addr_map #(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 24
) (
    input  logic [WIN_BITS-1:0] win_offset,
    output logic [ADDR_W-1:0]   cfg_addr
);

    localparam int PAD_W = ADDR_W - WIN_BITS - 1;

    // Purpose: assemble {1, zero pad, window offset}.
    always_comb begin
        cfg_addr = {1'b1, {PAD_W{1'b0}}, win_offset};
    end

endmodule

// File: rtl/cfgb_lane_swap.sv
// Reorders byte lanes by access size between big- and little-endian sides.
// Word: all lanes reversed. Halfword: lanes 0/1 exchanged. Byte: lane 0 kept.
// Lanes outside the access are zero. Reserved size gives all zero.
// The mapping is its own inverse, so it serves both directions.
module cfgb_lane_swap
    import cfgb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    localparam int NB   = DATA_W / 8;
    localparam int HALF = 2;

    logic [DATA_W-1:0] word_sw;
    logic [DATA_W-1:0] half_sw;
    logic [DATA_W-1:0] byte_sw;

    // Each lane's source is fixed per size variant, so the structure repeats.
    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign word_sw[i*8 +: 8] = din[(NB-1-i)*8 +: 8];
        if (i < HALF) begin : g_h
            assign half_sw[i*8 +: 8] = din[(HALF-1-i)*8 +: 8];
        end else begin : g_hz
            assign half_sw[i*8 +: 8] = 8'h00;
        end
        if (i == 0) begin : g_b
            assign byte_sw[i*8 +: 8] = din[7:0];
        end else begin : g_bz
            assign byte_sw[i*8 +: 8] = 8'h00;
        end
    end

    // Purpose: select the variant matching the access size.
    always_comb begin
        unique case (acc_size_e'(size))
            SZ_WORD: dout = word_sw;
            SZ_HALF: dout = half_sw;
            SZ_BYTE: dout = byte_sw;
            default: dout = '0;
        endcase
    end

endmodule

// File: rtl/cfgb_ctrl.sv
// Request controller: captures one access from a strobe while idle, holds
// the request until acknowledged, then raises a one-cycle read-valid.
// Assumes the requester acknowledges no earlier than the first req cycle.
module cfgb_ctrl
    import cfgb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [1:0]        size_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              ack,
    output logic              req,
    output logic              we,
    output logic [1:0]        size_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              rd_done
);

    req_state_e state;
    logic       accept;
    logic       finish;

    // Purpose: decide whether this edge takes a new access or ends one.
    always_comb begin
        accept = (state == ST_IDLE) && (wr_stb || rd_stb) &&
                 (acc_size_e'(size_in) != SZ_RSVD);
        finish = (state == ST_WAIT) && ack;
    end

    // Purpose: request state sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (accept) begin
            state <= ST_WAIT;
        end else if (finish) begin
            state <= ST_IDLE;
        end
    end

    // Purpose: capture the access fields; a write wins over a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we      <= 1'b0;
            size_q  <= 2'd0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            we      <= wr_stb;
            size_q  <= size_in;
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
        end
    end

    // Purpose: one-cycle marker that a read has just been answered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_done <= 1'b0;
        end else begin
            rd_done <= finish && !we;
        end
    end

    assign req = (state == ST_WAIT);

endmodule

// File: rtl/cfg_swap_bridge.sv
// Top of the configuration access bridge: address formation, write-lane
// reordering before capture, read-lane reordering on return and a
// registered read result. Synchronous active-low reset.
module cfg_swap_bridge
    import cfgb_pkg::*;
#(
    parameter int WIN_BITS = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        cpu_size,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    output logic              cpu_busy,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cfg_req,
    output logic              cfg_we,
    output logic [ADDR_W-1:0] cfg_addr,
    output logic [1:0]        cfg_size,
    output logic [DATA_W-1:0] cfg_wdata,
    input  logic              cfg_ack,
    input  logic [DATA_W-1:0] cfg_rdata
);

    logic [ADDR_W-1:0] mapped_addr;
    logic [DATA_W-1:0] wr_swapped;
    logic [DATA_W-1:0] rd_swapped;
    logic [DATA_W-1:0] rdata_q;
    logic              rd_done;
    logic              unused_hi_addr;

    // Bits above the window never reach the configuration side.
    assign unused_hi_addr = ^cpu_addr[ADDR_W-1:WIN_BITS];

    cfgb_addr_map #(
        .ADDR_W   (ADDR_W),
        .WIN_BITS (WIN_BITS)
    ) u_addr (
        .win_offset (cpu_addr[WIN_BITS-1:0]),
        .cfg_addr   (mapped_addr)
    );

    cfgb_lane_swap #(.DATA_W(DATA_W)) u_wr_swap (
        .size (cpu_size),
        .din  (cpu_wdata),
        .dout (wr_swapped)
    );

    cfgb_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (cpu_wr),
        .rd_stb   (cpu_rd),
        .size_in  (cpu_size),
        .addr_in  (mapped_addr),
        .wdata_in (wr_swapped),
        .ack      (cfg_ack),
        .req      (cfg_req),
        .we       (cfg_we),
        .size_q   (cfg_size),
        .addr_q   (cfg_addr),
        .wdata_q  (cfg_wdata),
        .rd_done  (rd_done)
    );

    cfgb_lane_swap #(.DATA_W(DATA_W)) u_rd_swap (
        .size (cfg_size),
        .din  (cfg_rdata),
        .dout (rd_swapped)
    );

    // Purpose: latch reordered read data at the acknowledging edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (cfg_req && cfg_ack && !cfg_we) begin
            rdata_q <= rd_swapped;
        end
    end

    assign cpu_rdata  = rdata_q;
    assign cpu_rvalid = rd_done;
    assign cpu_busy   = cfg_req;

endmodule

// File: rtl/cfg_swap_bridge_chk.sv
// Protocol checker for the configuration access bridge, bound to the top.
module cfg_swap_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_busy,
    input logic        cpu_rvalid,
    input logic        cfg_req,
    input logic        cfg_we,
    input logic [31:0] cfg_addr,
    input logic [1:0]  cfg_size,
    input logic [31:0] cfg_wdata,
    input logic        cfg_ack
);

    // R7: a request without acknowledge stays raised and unchanged.
    a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && !cfg_ack |=> cfg_req && $stable(cfg_addr) &&
        $stable(cfg_wdata) && $stable(cfg_we) && $stable(cfg_size));

    // R7: an acknowledged request is gone in the next cycle.
    a_r7_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && cfg_ack |=> !cfg_req && !cpu_busy);

    // R2: the address of every request carries the forced top bit.
    a_r2_addr_top: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> cfg_addr[31] && (cfg_addr[30:24] == 7'd0));

    // R6: read-valid is a single pulse following an acknowledged read.
    a_r6_rvalid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |=> !cpu_rvalid);

    a_r6_rvalid_cause: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |-> $past(cfg_req && cfg_ack && !cfg_we));

    // R9: a pending request never carries the reserved size.
    a_r9_no_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> cfg_size != 2'd3);

    // R7: busy mirrors a pending request.
    a_r7_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req == cpu_busy);

endmodule

bind cfg_swap_bridge cfg_swap_bridge_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_busy   (cpu_busy),
    .cpu_rvalid (cpu_rvalid),
    .cfg_req    (cfg_req),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_size   (cfg_size),
    .cfg_wdata  (cfg_wdata),
    .cfg_ack    (cfg_ack)
);

// File: tb/cfg_swap_bridge_bench.sv
// Bench for the configuration access bridge: vector table, then directed cases.
module cfg_swap_bridge_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    typedef struct packed {
        logic        we;
        logic [1:0]  size;
        logic [31:0] addr;
        logic [31:0] data;
        logic [31:0] rsp;
        logic [31:0] exp_addr;
        logic [31:0] exp_data;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 2'd2, 32'hFF12_3456, 32'h1122_3344, 32'h0, 32'h8012_3456, 32'h4433_2211},
        '{1'b1, 2'd1, 32'h0000_0800, 32'hABCD_1234, 32'h0, 32'h8000_0800, 32'h0000_3412},
        '{1'b1, 2'd0, 32'h1234_5679, 32'hDEAD_BE5A, 32'h0, 32'h8034_5679, 32'h0000_005A},
        '{1'b0, 2'd2, 32'h00FF_FFFC, 32'h0, 32'h7856_3412, 32'h80FF_FFFC, 32'h1234_5678},
        '{1'b0, 2'd1, 32'h7F00_0002, 32'h0, 32'hCAFE_BEEF, 32'h8000_0002, 32'h0000_EFBE},
        '{1'b0, 2'd0, 32'h8000_0003, 32'h0, 32'h1122_33A5, 32'h8000_0003, 32'h0000_00A5},
        '{1'b1, 2'd2, 32'h0000_0000, 32'h0000_0001, 32'h0, 32'h8000_0000, 32'h0100_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [1:0]  cpu_size = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic        cpu_busy;
    logic        cpu_rvalid;
    logic [31:0] cpu_rdata;
    logic        cfg_req;
    logic        cfg_we;
    logic [31:0] cfg_addr;
    logic [1:0]  cfg_size;
    logic [31:0] cfg_wdata;
    logic        cfg_ack = 1'b0;
    logic [31:0] cfg_rdata = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_swap_bridge u_cfg_swap_bridge (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_addr   (cpu_addr),
        .cpu_size   (cpu_size),
        .cpu_wdata  (cpu_wdata),
        .cpu_wr     (cpu_wr),
        .cpu_rd     (cpu_rd),
        .cpu_busy   (cpu_busy),
        .cpu_rvalid (cpu_rvalid),
        .cpu_rdata  (cpu_rdata),
        .cfg_req    (cfg_req),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_size   (cfg_size),
        .cfg_wdata  (cfg_wdata),
        .cfg_ack    (cfg_ack),
        .cfg_rdata  (cfg_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance to the middle of the next low phase.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // One access from strobe to result, checking each due cycle.
    task automatic run_vec(input vec_t v);
        cpu_addr  = v.addr;
        cpu_size  = v.size;
        cpu_wdata = v.data;
        cpu_wr    = v.we;
        cpu_rd    = !v.we;
        step();
        cpu_wr = 1'b0;
        cpu_rd = 1'b0;
        check("R7 req raised", {31'd0, cfg_req}, 32'd1);
        check("R7 busy raised", {31'd0, cpu_busy}, 32'd1);
        check("R2 address", cfg_addr, v.exp_addr);
        check("R11 size", {30'd0, cfg_size}, {30'd0, v.size});
        check("R10 direction", {31'd0, cfg_we}, {31'd0, v.we});
        if (v.we) check("R3 R4 R5 write lanes", cfg_wdata, v.exp_data);
        step();
        check("R7 req held", {31'd0, cfg_req}, 32'd1);
        check("R7 addr held", cfg_addr, v.exp_addr);
        cfg_ack   = 1'b1;
        cfg_rdata = v.rsp;
        step();
        cfg_ack   = 1'b0;
        cfg_rdata = '0;
        check("R7 req dropped", {31'd0, cfg_req}, 32'd0);
        check("R7 busy dropped", {31'd0, cpu_busy}, 32'd0);
        check("R6 rvalid", {31'd0, cpu_rvalid}, {31'd0, !v.we});
        if (!v.we) check("R6 read lanes", cpu_rdata, v.exp_data);
        step();
        check("R6 rvalid single", {31'd0, cpu_rvalid}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        // R1: idle outputs after reset.
        check("R1 req", {31'd0, cfg_req}, 32'd0);
        check("R1 busy", {31'd0, cpu_busy}, 32'd0);
        check("R1 rvalid", {31'd0, cpu_rvalid}, 32'd0);
        step();

        for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

        // R9: reserved size starts nothing.
        cpu_addr = 32'h0000_1000;
        cpu_size = 2'd3;
        cpu_rd   = 1'b1;
        step();
        cpu_rd = 1'b0;
        check("R9 no req", {31'd0, cfg_req}, 32'd0);
        check("R9 not busy", {31'd0, cpu_busy}, 32'd0);
        step();
        check("R9 no rvalid", {31'd0, cpu_rvalid}, 32'd0);

        // R10: both strobes give a write.
        cpu_addr  = 32'h0000_0040;
        cpu_size  = 2'd2;
        cpu_wdata = 32'hA1B2_C3D4;
        cpu_wr    = 1'b1;
        cpu_rd    = 1'b1;
        step();
        cpu_wr = 1'b0;
        cpu_rd = 1'b0;
        check("R10 write wins", {31'd0, cfg_we}, 32'd1);
        check("R10 data", cfg_wdata, 32'hD4C3_B2A1);
        cfg_ack = 1'b1;
        step();
        cfg_ack = 1'b0;
        check("R10 no rvalid", {31'd0, cpu_rvalid}, 32'd0);

        // R8: a strobe during a pending read is ignored.
        cpu_addr = 32'h0000_0104;
        cpu_size = 2'd2;
        cpu_rd   = 1'b1;
        step();
        cpu_rd    = 1'b0;
        cpu_addr  = 32'h00AB_CDE0;
        cpu_size  = 2'd0;
        cpu_wdata = 32'h0000_0077;
        cpu_wr    = 1'b1;
        step();
        cpu_wr = 1'b0;
        check("R8 addr kept", cfg_addr, 32'h8000_0104);
        check("R8 size kept", {30'd0, cfg_size}, 32'd2);
        check("R8 still read", {31'd0, cfg_we}, 32'd0);
        cfg_ack   = 1'b1;
        cfg_rdata = 32'h0403_0201;
        step();
        cfg_ack = 1'b0;
        check("R8 read result", cpu_rdata, 32'h0102_0304);
        check("R8 no new req", {31'd0, cfg_req}, 32'd0);
        step();
        check("R8 still idle", {31'd0, cfg_req}, 32'd0);

        // R1: reset in the middle of a pending request.
        cpu_addr = 32'h0000_0200;
        cpu_size = 2'd1;
        cpu_rd   = 1'b1;
        step();
        cpu_rd = 1'b0;
        rst_n  = 1'b0;
        step();
        rst_n = 1'b1;
        check("R1 req after reset", {31'd0, cfg_req}, 32'd0);
        check("R1 busy after reset", {31'd0, cpu_busy}, 32'd0);

        finish_run();
    end

endmodule